// File: doc/BRIEF.md
# Serial Control Latch Loader

This block keeps an eight-bit control image and copies it into an external serial-in, parallel-out shift register that has a separate output strobe. The image sets board-level controls. Bits 0 and 1 pick internal clocking for serial ports 0 and 1. Bits 2 and 3 are the active-low data-terminal-ready lines of those ports. Bit 4 is a spare external output and bit 5 is an auto-reset control. Bit 6 is an active-low PCI reset and bit 7 is an active-low EEPROM write control. The shift clock and shift data wires are also the clock and data wires of a shared two-wire bus. For that reason the block releases both wires high after every transfer, so the bus can see a START condition.

Software-side logic changes the image in one of two ways: it writes a whole byte, or it raises per-bit set and clear requests. A write, or any request that actually changes a bit, causes one complete shift-and-latch sequence. The sequence starts only when the shared-bus owner grants access. Every change on a line is followed by a settle time of a programmable number of system clock cycles, sized for about 3 µs. A busy flag covers the whole sequence, and a one-cycle done pulse marks its end.

Top module: `ctl_shift_loader`

## Requirements
- R1: While no transfer is running, the shift clock and shift data outputs are 1 and the strobe output is 0.
- R2: Reset loads the image with INIT_IMAGE (default 0xCC: bits 2, 3, 6 and 7 high) and requests one transfer of it.
- R3: A transfer starts only in a cycle where bus_grant is 1. A pending update is held, not lost, while the grant is low.
- R4: wr_en loads wr_data into the image and always requests a transfer, even if the value is unchanged. wr_en takes priority over set_req and clr_req in the same cycle. The external register receives the byte with bit 7 shifted first.
- R5: set_req bits set and clr_req bits clear the matching image bits, and clear wins when both are raised for one bit. A transfer is requested only if the image value changes.
- R6: For each bit, the sequence is: clock goes low, then data takes the bit, then clock rises. Data is stable at the rising edge. Every line change is held for SETTLE_CYCLES cycles. The falling and rising edge of one clock pulse are 2*SETTLE_CYCLES apart, and a whole transfer lasts 29*SETTLE_CYCLES cycles from the start to done.
- R7: After the eighth rising clock edge, strobe goes high and then low. Then clock goes low, data goes high and clock goes high, in that order.
- R8: Requests that arrive during a transfer are merged into the image. Exactly one more transfer follows, and it carries the final merged value.
- R9: done is a single-cycle pulse, raised in the same cycle that busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_grant | input | 1 | Shared-bus owner permits a transfer |
| wr_en | input | 1 | Load the whole image from wr_data |
| wr_data | input | 8 | New image value |
| set_req | input | 8 | Per-bit set requests |
| clr_req | input | 8 | Per-bit clear requests (override set) |
| image | output | 8 | Current control image |
| sclk_o | output | 1 | Shift clock, shared bus clock wire |
| sdat_o | output | 1 | Shift data, shared bus data wire |
| strobe_o | output | 1 | Output latch strobe |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The bench builds the block with SETTLE_CYCLES = 2. This makes a transfer 58 cycles long, short enough to write all 256 image values through a modelled external shift register and latch. The bench also sets and clears every bit on its own. The short settle time keeps edge spacing and total length cheap to measure on every transfer. Holding the grant low and issuing requests in the middle of a transfer then covers deferral and merging in a few hundred cycles.

// File: rtl/ctl_shift_loader.sv
module ctl_shift_loader #(
  parameter int          SETTLE_CYCLES = 375,
  parameter logic [7:0]  INIT_IMAGE    = 8'hCC
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_grant,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic [7:0] set_req,
  input  logic [7:0] clr_req,
  output logic [7:0] image,
  output logic       sclk_o,
  output logic       sdat_o,
  output logic       strobe_o,
  output logic       busy,
  output logic       done
);
  localparam int         TW        = $clog2(SETTLE_CYCLES + 1);
  localparam logic [4:0] LAST_STEP = 5'd28;
  localparam logic [4:0] BIT_STEPS = 5'd24;
  localparam logic [TW-1:0] RELOAD = TW'(SETTLE_CYCLES - 1);

  logic [7:0]    img_q, img_d, snap_q;
  logic          pend_q, busy_q, scl_q, sda_q, str_q, done_q;
  logic [4:0]    step_q, nxt, ph;
  logic [2:0]    bidx;
  logic [TW-1:0] tmr_q;
  logic          req, start, tick, fin;

  assign img_d = wr_en ? wr_data : ((img_q | set_req) & ~clr_req);
  assign req   = wr_en | (img_d != img_q);
  assign start = !busy_q && pend_q && bus_grant;
  assign tick  = busy_q && (tmr_q == '0);
  assign fin   = tick && (step_q == LAST_STEP);
  assign nxt   = step_q + 5'd1;
  assign ph    = nxt % 5'd3;
  assign bidx  = 3'(nxt / 5'd3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      img_q  <= INIT_IMAGE;
      pend_q <= 1'b1;
      busy_q <= 1'b0;
      step_q <= '0;
      tmr_q  <= '0;
      snap_q <= '0;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      str_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      img_q  <= img_d;
      pend_q <= req | (pend_q & ~start);
      done_q <= 1'b0;
      if (start) begin
        busy_q <= 1'b1;
        step_q <= '0;
        tmr_q  <= RELOAD;
        snap_q <= img_q;
        scl_q  <= 1'b0;
      end else if (fin) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else if (tick) begin
        step_q <= nxt;
        tmr_q  <= RELOAD;
        if (nxt < BIT_STEPS) begin
          case (ph)
            5'd0:    scl_q <= 1'b0;
            5'd1:    sda_q <= snap_q[3'd7 - bidx];
            default: scl_q <= 1'b1;
          endcase
        end else begin
          case (nxt)
            5'd24:   str_q <= 1'b1;
            5'd25:   str_q <= 1'b0;
            5'd26:   scl_q <= 1'b0;
            5'd27:   sda_q <= 1'b1;
            default: scl_q <= 1'b1;
          endcase
        end
      end else if (busy_q) begin
        tmr_q <= tmr_q - 1'b1;
      end
    end
  end

  assign image    = img_q;
  assign sclk_o   = scl_q;
  assign sdat_o   = sda_q;
  assign strobe_o = str_q;
  assign busy     = busy_q;
  assign done     = done_q;

  assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (scl_q && sda_q && !str_q));

  assert_grant_before_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(bus_grant));

  assert_data_stable_at_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_q) |-> $stable(sda_q));

  assert_one_line_at_a_time_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({scl_q ^ $past(scl_q), sda_q ^ $past(sda_q), str_q ^ $past(str_q)}) <= 1);

  assert_strobe_with_clock_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(str_q) |-> (scl_q && busy_q));

  assert_request_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && req) |=> pend_q);

  assert_done_with_busy_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($fell(busy_q)));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: tb/ctl_shift_loader_tb.sv
module ctl_shift_loader_tb;
  localparam int ST   = 2;
  localparam int XFER = 29 * ST;

  logic clk = 1'b0, rst_n = 1'b0, bus_grant = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0, set_req = '0, clr_req = '0;
  logic [7:0] image;
  logic sclk_o, sdat_o, strobe_o, busy, done;

  int tests = 0, fails = 0;
  int cyc = 0, xfers = 0, gap_err = 0, len_err = 0, tail_err = 0, dpulse_err = 0;
  int fall_t = 0, start_t = 0, rise_cnt = 0, str_falls = 0;
  logic [7:0] ext_sr = '0, ext_q = '0;
  logic p_scl = 1'b1, p_str = 1'b0, p_busy = 1'b0, p_done = 1'b0;

  ctl_shift_loader #(.SETTLE_CYCLES(ST), .INIT_IMAGE(8'hCC)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_grant(bus_grant), .wr_en(wr_en), .wr_data(wr_data),
    .set_req(set_req), .clr_req(clr_req), .image(image), .sclk_o(sclk_o), .sdat_o(sdat_o),
    .strobe_o(strobe_o), .busy(busy), .done(done));

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (busy && !p_busy) begin start_t = cyc; rise_cnt = 0; str_falls = 0; end
      if (!sclk_o && p_scl) fall_t = cyc;
      if (sclk_o && !p_scl) begin
        rise_cnt++;
        ext_sr = {ext_sr[6:0], sdat_o};
        if (cyc - fall_t != 2 * ST) gap_err++;
        if (rise_cnt == 9 && !(sdat_o && !strobe_o && str_falls == 1)) tail_err++;
      end
      if (strobe_o && !p_str) begin
        ext_q = ext_sr;
        if (rise_cnt != 8) tail_err++;
      end
      if (!strobe_o && p_str) str_falls++;
      if (done) begin
        xfers++;
        if (cyc - start_t != XFER) len_err++;
        if (busy || p_done) dpulse_err++;
      end
    end
    p_scl = sclk_o; p_str = strobe_o; p_busy = busy; p_done = done;
  end

  task automatic wait_xfers(input int target);
    for (int i = 0; i < 8 * XFER && xfers < target; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic do_write(input logic [7:0] v);
    int x0;
    x0 = xfers;
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    wait_xfers(x0 + 1);
  endtask

  task automatic pulse_req(input logic [7:0] s, input logic [7:0] c);
    set_req = s; clr_req = c;
    @(negedge clk);
    set_req = '0; clr_req = '0;
  endtask

  initial begin
    int x0;
    repeat (5) @(negedge clk);
    chk(sclk_o && sdat_o && !strobe_o && !busy, "R1 idle lines in reset", {sclk_o, sdat_o, strobe_o, busy}, 4'b1100);
    chk(image == 8'hCC, "R2 reset image", image, 8'hCC);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(!busy && xfers == 0, "R3 no start without grant", xfers, 0);
    chk(sclk_o && sdat_o && !strobe_o, "R1 idle while waiting", {sclk_o, sdat_o, strobe_o}, 3'b110);
    bus_grant = 1'b1;
    wait_xfers(1);
    chk(xfers == 1 && ext_q == 8'hCC, "R2 initial image shifted once", ext_q, 8'hCC);

    for (int v = 0; v < 256; v++) begin
      do_write(8'(v));
      chk(ext_q == 8'(v) && image == 8'(v), "R4 write sweep latched MSB first", ext_q, v);
    end
    x0 = xfers;
    do_write(8'hFF);
    chk(xfers == x0 + 1, "R4 unchanged write still transfers", xfers - x0, 1);
    chk(sclk_o && sdat_o && !strobe_o && !busy, "R1 idle after transfer", {sclk_o, sdat_o, strobe_o}, 3'b110);

    for (int b = 0; b < 8; b++) begin
      do_write(8'h00);
      x0 = xfers;
      pulse_req(8'(1 << b), 8'h00);
      wait_xfers(x0 + 1);
      chk(ext_q == 8'(1 << b) && xfers == x0 + 1, "R5 set single bit", ext_q, 1 << b);
      x0 = xfers;
      pulse_req(8'(1 << b), 8'h00);
      repeat (2 * XFER) @(negedge clk);
      chk(xfers == x0, "R5 set of set bit makes no transfer", xfers - x0, 0);
      pulse_req(8'h00, 8'(1 << b));
      wait_xfers(x0 + 1);
      chk(ext_q == 8'h00 && image == 8'h00, "R5 clear single bit", ext_q, 0);
    end

    do_write(8'h08);
    x0 = xfers;
    pulse_req(8'h08, 8'h08);
    wait_xfers(x0 + 1);
    chk(image == 8'h00 && ext_q == 8'h00, "R5 clear wins over set", ext_q, 0);

    x0 = xfers;
    wr_en = 1'b1; wr_data = 8'h55; set_req = 8'hFF;
    @(negedge clk);
    wr_en = 1'b0; set_req = '0;
    wait_xfers(x0 + 1);
    chk(image == 8'h55 && ext_q == 8'h55, "R4 write beats set", ext_q, 8'h55);

    do_write(8'h00);
    x0 = xfers;
    pulse_req(8'h01, 8'h00);
    repeat (5) @(negedge clk);
    pulse_req(8'h80, 8'h00);
    repeat (5) @(negedge clk);
    pulse_req(8'h00, 8'h01);
    repeat (4 * XFER) @(negedge clk);
    chk(xfers == x0 + 2, "R8 exactly one follow-up transfer", xfers - x0, 2);
    chk(ext_q == 8'h80, "R8 merged value latched", ext_q, 8'h80);

    bus_grant = 1'b0;
    x0 = xfers;
    wr_en = 1'b1; wr_data = 8'h3C;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (3 * XFER) @(negedge clk);
    chk(xfers == x0 && ext_q == 8'h80 && !busy, "R3 held while grant low", ext_q, 8'h80);
    bus_grant = 1'b1;
    wait_xfers(x0 + 1);
    chk(ext_q == 8'h3C, "R3 deferred update delivered", ext_q, 8'h3C);

    chk(gap_err == 0, "R6 clock pulse spacing", gap_err, 0);
    chk(len_err == 0, "R6 transfer length", len_err, 0);
    chk(tail_err == 0, "R7 strobe and bus release order", tail_err, 0);
    chk(dpulse_err == 0, "R9 done pulse with busy low", dpulse_err, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule